// File: doc/BRIEF.md
# Transfer Reset and Enable Sequencer

This controller runs in the control clock domain of a DMA engine. It drives the reset and enable of two data-path clock domains: a source domain that produces data and a destination domain that consumes it. One reset sequence serves two cases. It runs after power-up, and it runs again to clear out an aborted transfer. No pipeline is flushed one item at a time.

When an abort arrives, the controller keeps both data domains enabled until each reports idle, so in-flight protocol transactions can complete. It then drives reset into both domains. Each domain counts edges of its own clock while in reset and sends an acknowledgment back. Both resets stay high until both acknowledgments are seen, so the slowest domain sets the length. The resets are then released in turn, first the destination and then the source. The sink is therefore ready before the source can send anything.

Pause disables both data domains and asserts no reset. On resume they continue from the state they held. Every request into a data domain passes through a two-flop synchronizer, and every acknowledgment or idle flag coming back passes through two flops as well.

Top module: `xfer_rst_seq`

## Requirements
- R1: After an abort in the running state, no data-domain reset is asserted until both `src_idle` and `dst_idle` have been high, and both domain enables stay high while waiting. Once both idle flags are high, both resets assert.
- R2: While `rst` is high, both domain resets are high, both enables are low, and `xfer_ready` and `abort_done` are low. After `rst` falls, the same release sequence used after an abort runs and ends with `xfer_ready`=1, `abort_done`=0 and both resets low.
- R3: Each data-domain reset stays high for at least RESET_CYCLES (default 4) edges of that domain's own clock. The destination reset is not released before the source domain has also been in reset for that many of its own edges.
- R4: The destination reset is released before the source reset. The source reset never falls while the destination reset is still high.
- R5: While `xfer_pause` is held in the running state, both domain enables go low and no reset is asserted. When pause is removed, both enables return high without any reset.
- R6: An abort that arrives while paused re-enables both data domains so they can drain. No reset is asserted until both idle flags are high.
- R7: When the abort sequence finishes, `abort_done`=1 and `xfer_ready`=1. A following `xfer_start` clears both on the next control clock and re-enables both domains.
- R8: `xfer_start` while ready drops `xfer_ready` one control clock later and raises both domain enables within SYNC_STAGES+1 edges of each domain clock.
- R9: `xfer_abort` and `xfer_pause` have no effect while the block is ready. `xfer_ready` stays 1, `abort_done` keeps its value, and no reset or enable is asserted in either domain.
- R10: In each data domain, the enable is never high while that domain's reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Power-up reset, active high, synchronous to `clk`; also presets the data-domain reset flops |
| xfer_start | input | 1 | Start a transfer when the block is ready |
| xfer_pause | input | 1 | Level: disable the data domains while high |
| xfer_abort | input | 1 | Pulse: abort the running or paused transfer |
| xfer_ready | output | 1 | Reset sequence complete, a transfer can start |
| abort_done | output | 1 | Ready state was reached through an abort |
| src_clk | input | 1 | Source data-domain clock |
| src_idle | input | 1 | Source domain has no pending transactions (source clock) |
| src_rst | output | 1 | Source domain reset, active high (source clock) |
| src_en | output | 1 | Source domain enable (source clock) |
| dst_clk | input | 1 | Destination data-domain clock |
| dst_idle | input | 1 | Destination domain has no pending transactions (destination clock) |
| dst_rst | output | 1 | Destination domain reset, active high (destination clock) |
| dst_en | output | 1 | Destination domain enable (destination clock) |

## Verification
The control-side outputs `xfer_ready` and `abort_done` come from state registers. Each one is checked exactly one control clock after the edge that samples the stimulus. The domain enables and resets cross a two-flop synchronizer and then an output register, so they move within three edges of their own clock. The bench therefore samples them after a fixed window of 14 control clocks, which is longer than three edges of the slowest domain. Reset assertion and the full release sequence depend on an acknowledgment round trip, so they are awaited in bounded loops. Throughout the run, monitors check the ordering and exclusion rules on every control cycle and count each domain's reset length on its own clock.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
package xrs_pkg;
  localparam int XRS_NUM_DOM = 2;
  localparam int DOM_DST     = 0;   // sink side, released first
  localparam int DOM_SRC     = 1;   // source side, released last

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PAUSE,
    ST_WAIT_IDLE,
    ST_ASSERT_RST,
    ST_REL_DEST,
    ST_REL_SRC,
    ST_SHUTDOWN
  } xrs_state_e;
endpackage

// File: rtl/xrs_dom_link.sv
`timescale 1ns/1ps
module xrs_dom_link #(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_CYCLES = 4
) (
  input  logic clk_ctrl,
  input  logic rst,
  input  logic rst_req,
  input  logic en_req,
  output logic ack_ctrl,
  output logic idle_ctrl,
  input  logic clk_dom,
  input  logic dom_idle,
  output logic dom_rst,
  output logic dom_en
);
  localparam int CW = (RESET_CYCLES > 2) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(RESET_CYCLES - 1);

  logic [SYNC_STAGES-1:0] rst_pipe, en_pipe;
  logic [SYNC_STAGES-1:0] ack_pipe, idle_pipe;
  logic [CW-1:0]          hold_cnt;
  logic                   dom_rst_q, dom_en_q, ack_q;

  // Data-domain side: the power-up reset presets the domain into reset
  // asynchronously; the request input is also high then, so release is clean.
  always_ff @(posedge clk_dom or posedge rst) begin
    if (rst) begin
      rst_pipe  <= '1;
      en_pipe   <= '0;
      dom_rst_q <= 1'b1;
      dom_en_q  <= 1'b0;
      hold_cnt  <= '0;
      ack_q     <= 1'b0;
    end else begin
      rst_pipe  <= {rst_pipe[SYNC_STAGES-2:0], rst_req};
      en_pipe   <= {en_pipe[SYNC_STAGES-2:0], en_req};
      dom_rst_q <= rst_pipe[SYNC_STAGES-1];
      dom_en_q  <= en_pipe[SYNC_STAGES-1] & ~rst_pipe[SYNC_STAGES-1];
      if (dom_rst_q) begin
        if (hold_cnt != CNT_LAST) hold_cnt <= hold_cnt + 1'b1;
        ack_q <= (hold_cnt == CNT_LAST);
      end else begin
        hold_cnt <= '0;
        ack_q    <= 1'b0;
      end
    end
  end

  // Control-domain side: bring acknowledgment and idle back.
  always_ff @(posedge clk_ctrl) begin
    if (rst) begin
      ack_pipe  <= '0;
      idle_pipe <= '0;
    end else begin
      ack_pipe  <= {ack_pipe[SYNC_STAGES-2:0], ack_q};
      idle_pipe <= {idle_pipe[SYNC_STAGES-2:0], dom_idle};
    end
  end

  assign dom_rst   = dom_rst_q;
  assign dom_en    = dom_en_q;
  assign ack_ctrl  = ack_pipe[SYNC_STAGES-1];
  assign idle_ctrl = idle_pipe[SYNC_STAGES-1];

  // R3: acknowledgment only rises after the domain has been held in reset
  assert_ack_in_reset_R3: assert property (@(posedge clk_dom) disable iff (rst)
    $rose(ack_q) |-> $past(dom_rst_q));
endmodule

// File: rtl/xrs_fsm.sv
`timescale 1ns/1ps
module xrs_fsm
  import xrs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   pause_i,
  input  logic                   abort_i,
  input  logic [XRS_NUM_DOM-1:0] ack_i,
  input  logic [XRS_NUM_DOM-1:0] idle_i,
  output logic [XRS_NUM_DOM-1:0] rst_req_o,
  output logic                   en_req_o,
  output logic                   ready_o,
  output logic                   aborted_o
);
  xrs_state_e state_q, state_d;
  logic       from_abort_q;
  logic [XRS_NUM_DOM-1:0] rst_req_q;
  logic en_req_q, ready_q, aborted_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_SHUTDOWN: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (abort_i)      state_d = ST_WAIT_IDLE;
        else if (pause_i) state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (abort_i)       state_d = ST_WAIT_IDLE;
        else if (!pause_i) state_d = ST_RUN;
      end
      ST_WAIT_IDLE:  if (&idle_i) state_d = ST_ASSERT_RST;
      ST_ASSERT_RST: if (&ack_i) state_d = ST_REL_DEST;
      ST_REL_DEST:   if (!ack_i[DOM_DST]) state_d = ST_REL_SRC;
      ST_REL_SRC:    if (!ack_i[DOM_SRC]) state_d = from_abort_q ? ST_SHUTDOWN : ST_IDLE;
      default:       state_d = ST_ASSERT_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_ASSERT_RST;
      from_abort_q <= 1'b0;
      rst_req_q    <= '1;
      en_req_q     <= 1'b0;
      ready_q      <= 1'b0;
      aborted_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_WAIT_IDLE) from_abort_q <= 1'b1;
      rst_req_q[DOM_DST] <= (state_d == ST_ASSERT_RST);
      rst_req_q[DOM_SRC] <= (state_d == ST_ASSERT_RST) || (state_d == ST_REL_DEST);
      en_req_q  <= (state_d == ST_RUN) || (state_d == ST_WAIT_IDLE);
      ready_q   <= (state_d == ST_IDLE) || (state_d == ST_SHUTDOWN);
      aborted_q <= (state_d == ST_SHUTDOWN);
    end
  end

  assign rst_req_o = rst_req_q;
  assign en_req_o  = en_req_q;
  assign ready_o   = ready_q;
  assign aborted_o = aborted_q;

  // R1: a reset request only rises once both domains were seen idle
  assert_idle_before_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_q[DOM_DST]) |-> $past(&idle_i));

  // R3: destination release only after both domains acknowledged their hold
  assert_hold_both_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req_q[DOM_DST]) |-> $past(&ack_i));

  // R4: source release only after destination reset was seen gone
  assert_dest_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req_q[DOM_SRC]) |-> ($past(!ack_i[DOM_DST]) && !rst_req_q[DOM_DST]));

  // R5: leaving or staying in pause never requests a reset
  assert_pause_no_reset_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_PAUSE) |-> (rst_req_q == '0));
endmodule

// File: rtl/xfer_rst_seq.sv
`timescale 1ns/1ps
module xfer_rst_seq
  import xrs_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic xfer_start,
  input  logic xfer_pause,
  input  logic xfer_abort,
  output logic xfer_ready,
  output logic abort_done,
  input  logic src_clk,
  input  logic src_idle,
  output logic src_rst,
  output logic src_en,
  input  logic dst_clk,
  input  logic dst_idle,
  output logic dst_rst,
  output logic dst_en
);
  logic [XRS_NUM_DOM-1:0] dom_clk, dom_idle, dom_rst, dom_en;
  logic [XRS_NUM_DOM-1:0] ack_ctrl, idle_ctrl, rst_req;
  logic                   en_req;

  assign dom_clk[DOM_SRC]  = src_clk;
  assign dom_clk[DOM_DST]  = dst_clk;
  assign dom_idle[DOM_SRC] = src_idle;
  assign dom_idle[DOM_DST] = dst_idle;

  xrs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (xfer_start),
    .pause_i   (xfer_pause),
    .abort_i   (xfer_abort),
    .ack_i     (ack_ctrl),
    .idle_i    (idle_ctrl),
    .rst_req_o (rst_req),
    .en_req_o  (en_req),
    .ready_o   (xfer_ready),
    .aborted_o (abort_done)
  );

  for (genvar d = 0; d < XRS_NUM_DOM; d++) begin : g_dom
    xrs_dom_link #(
      .SYNC_STAGES  (SYNC_STAGES),
      .RESET_CYCLES (RESET_CYCLES)
    ) u_link (
      .clk_ctrl  (clk),
      .rst       (rst),
      .rst_req   (rst_req[d]),
      .en_req    (en_req),
      .ack_ctrl  (ack_ctrl[d]),
      .idle_ctrl (idle_ctrl[d]),
      .clk_dom   (dom_clk[d]),
      .dom_idle  (dom_idle[d]),
      .dom_rst   (dom_rst[d]),
      .dom_en    (dom_en[d])
    );
  end

  assign src_rst = dom_rst[DOM_SRC];
  assign src_en  = dom_en[DOM_SRC];
  assign dst_rst = dom_rst[DOM_DST];
  assign dst_en  = dom_en[DOM_DST];
endmodule

// File: tb/tb_xfer_rst_seq.sv
`timescale 1ns/1ps
module tb_xfer_rst_seq;
  logic clk = 1'b0, src_clk = 1'b0, dst_clk = 1'b0, rst = 1'b1;
  logic xfer_start = 1'b0, xfer_pause = 1'b0, xfer_abort = 1'b0;
  logic src_idle = 1'b1, dst_idle = 1'b1;
  logic xfer_ready, abort_done, src_rst, src_en, dst_rst, dst_en;

  always #2   clk     = ~clk;      // 250 MHz control clock
  always #3.5 src_clk = ~src_clk;  // source domain, edges on half-ns
  always #5.5 dst_clk = ~dst_clk;  // destination domain, slowest

  xfer_rst_seq dut (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_pause(xfer_pause),
    .xfer_abort(xfer_abort), .xfer_ready(xfer_ready), .abort_done(abort_done),
    .src_clk(src_clk), .src_idle(src_idle), .src_rst(src_rst), .src_en(src_en),
    .dst_clk(dst_clk), .dst_idle(dst_idle), .dst_rst(dst_rst), .dst_en(dst_en)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0, mon_on = 0, forbid_rst = 0, forbid_en = 0, require_en = 0;
  bit prev_src = 1;
  string rst_tag = "R9", en_tag = "R9";
  int s_cnt = 0, d_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input int lim, input bit want_done);
    for (int i = 0; i < lim && !(xfer_ready && abort_done == want_done); i++) @(negedge clk);
  endtask

  task automatic wait_rst_on(input int lim);
    for (int i = 0; i < lim && !(src_rst && dst_rst); i++) @(negedge clk);
  endtask

  task automatic pulse_abort();
    xfer_abort = 1'b1; cyc(1); xfer_abort = 1'b0;
  endtask

  // Per-cycle reference rules, sampled 1 ns after the control negedge.
  always @(negedge clk) begin
    #1;
    if (mon_on && !rst) begin
      check(!(src_en && src_rst), "R10", src_en, 0, "source enabled in reset");
      check(!(dst_en && dst_rst), "R10", dst_en, 0, "destination enabled in reset");
      if (forbid_rst)
        check(!src_rst && !dst_rst, rst_tag, {src_rst, dst_rst}, 0, "reset asserted");
      if (forbid_en)
        check(!src_en && !dst_en, en_tag, {src_en, dst_en}, 0, "enable asserted");
      if (require_en)
        check(src_en && dst_en, "R1", {src_en, dst_en}, 3, "enable lost while draining");
      if (prev_src && !src_rst)
        check(!dst_rst, "R4", dst_rst, 0, "source released before destination");
      prev_src = src_rst;
    end
  end

  // Reset length in each domain, counted on that domain's own clock.
  always @(negedge src_clk) begin
    if (src_rst) s_cnt++;
    else begin
      if (s_cnt > 0) check(s_cnt >= 4, "R3", s_cnt, 4, "source reset too short");
      s_cnt = 0;
    end
  end

  always @(negedge dst_clk) begin
    if (dst_rst) d_cnt++;
    else begin
      if (d_cnt > 0) begin
        check(d_cnt >= 4, "R3", d_cnt, 4, "destination reset too short");
        check(s_cnt >= 4, "R3", s_cnt, 4, "destination released before source held");
      end
      d_cnt = 0;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R2: power-up reset state
    cyc(6);
    check(src_rst && dst_rst, "R2", {src_rst, dst_rst}, 3, "resets during rst");
    check(!src_en && !dst_en, "R2", {src_en, dst_en}, 0, "enables during rst");
    check(!xfer_ready && !abort_done, "R2", {xfer_ready, abort_done}, 0, "status during rst");
    rst = 1'b0; mon_on = 1'b1;
    wait_ready(300, 1'b0);
    check(xfer_ready == 1'b1, "R2", xfer_ready, 1, "ready after power-up");
    check(abort_done == 1'b0, "R2", abort_done, 0, "abort_done after power-up");
    check(!src_rst && !dst_rst, "R2", {src_rst, dst_rst}, 0, "resets released");

    // R9: abort and pause ignored while ready
    rst_tag = "R9"; en_tag = "R9"; forbid_rst = 1; forbid_en = 1;
    pulse_abort();
    xfer_pause = 1'b1; cyc(2); xfer_pause = 1'b0;
    cyc(30);
    check(xfer_ready == 1'b1, "R9", xfer_ready, 1, "ready after ignored controls");
    check(abort_done == 1'b0, "R9", abort_done, 0, "abort_done after ignored abort");
    forbid_en = 0;

    // R8: start a transfer
    rst_tag = "R8";
    xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
    check(xfer_ready == 1'b0, "R8", xfer_ready, 1'b0, "ready one cycle after start");
    cyc(14);
    check(src_en && dst_en, "R8", {src_en, dst_en}, 3, "enables after start");

    // R5: pause and resume, no reset
    rst_tag = "R5";
    xfer_pause = 1'b1; cyc(14);
    check(!src_en && !dst_en, "R5", {src_en, dst_en}, 0, "enables while paused");
    en_tag = "R5"; forbid_en = 1; cyc(20); forbid_en = 0;
    xfer_pause = 1'b0; cyc(14);
    check(src_en && dst_en, "R5", {src_en, dst_en}, 3, "enables after resume");
    check(xfer_ready == 1'b0, "R5", xfer_ready, 0, "still running after resume");

    // R1: abort waits for both idle flags
    rst_tag = "R1";
    src_idle = 1'b0; dst_idle = 1'b0; cyc(4);
    require_en = 1;
    pulse_abort();
    cyc(30);
    dst_idle = 1'b1; cyc(25);
    check(!src_rst && !dst_rst, "R1", {src_rst, dst_rst}, 0, "reset with source busy");
    src_idle = 1'b1; forbid_rst = 0; require_en = 0;
    wait_rst_on(60);
    check(src_rst && dst_rst, "R1", {src_rst, dst_rst}, 3, "reset after both idle");

    // R7: abort completes into shutdown
    wait_ready(300, 1'b1);
    check(xfer_ready && abort_done, "R7", {xfer_ready, abort_done}, 3, "shutdown state");
    check(!src_rst && !dst_rst, "R7", {src_rst, dst_rst}, 0, "resets released after abort");
    rst_tag = "R7"; forbid_rst = 1;
    xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
    check(!xfer_ready && !abort_done, "R7", {xfer_ready, abort_done}, 0, "status after restart");
    cyc(14);
    check(src_en && dst_en, "R7", {src_en, dst_en}, 3, "enables after restart");

    // R6: abort while paused re-enables before any reset
    rst_tag = "R6";
    xfer_pause = 1'b1; cyc(14);
    check(!src_en && !dst_en, "R6", {src_en, dst_en}, 0, "paused before abort");
    src_idle = 1'b0; dst_idle = 1'b0; cyc(2);
    pulse_abort();
    cyc(14);
    check(src_en && dst_en, "R6", {src_en, dst_en}, 3, "re-enabled to drain");
    cyc(10);
    src_idle = 1'b1; dst_idle = 1'b1; forbid_rst = 0;
    wait_rst_on(60);
    check(src_rst && dst_rst, "R6", {src_rst, dst_rst}, 3, "reset after drain");
    wait_ready(300, 1'b1);
    check(xfer_ready && abort_done, "R6", {xfer_ready, abort_done}, 3, "ready after paused abort");
    xfer_pause = 1'b0;
    cyc(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule